// File: doc/BRIEF.md
# SMBus Block-Mode Configuration Register Target

This block is a serial-bus target that lets a host read and program a small bank of 8-bit configuration registers. It watches SCL and SDA, which arrive already synchronised to the local clock. It pulls SDA low through an open-drain enable, and it presents the whole register bank as one flat vector for the rest of the chip to use. The 7-bit device address is 0x69, so the host writes to it with the address byte 0xD2 and reads from it with 0xD3.

The first byte after a write address is a command. Its low seven bits select the starting register, and its top bit chooses the protocol. With the top bit clear, SMBus block protocol is used: a block write carries a byte count, and a block read returns a byte count before the data. With the top bit set, plain I2C byte protocol is used and no count byte is sent in either direction. The count that a block read reports comes from a programmable register in the bank. Some fields are fixed or reserved: writes to them are acknowledged but leave them unchanged.

The controller is a single state machine with these states: IDLE, ADDR, ADDR_ACK, CMD, CMD_ACK, CNT, CNT_ACK, WR, WR_ACK, TX and TX_ACK. Its transitions are:
- A START from any state goes to ADDR. A STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK when the address matches. When it does not match, it goes to IDLE.
- ADDR_ACK goes to TX for a read and to CMD for a write.
- CMD goes to CMD_ACK. CMD_ACK then goes to WR in byte mode and to CNT in block mode.
- CNT goes to CNT_ACK, and CNT_ACK goes to WR.
- WR and WR_ACK alternate, one pass per data byte.
- TX goes to TX_ACK. TX_ACK goes back to TX when the host acknowledges and to IDLE when it does not.

Top module: `smb_cfg_target`

## Requirements
- R1: After reset the bank holds these values. Register 0 = 0x07. Registers 1 and 2 = 0xFF. Registers 3, 4 and 5 = 0x00. Register 6 = 0x45. Register 7 = 0x11. Register 8 = 0x05.
- R2: The address bytes 0xD2 (write) and 0xD3 (read) are acknowledged by driving SDA low during the ninth clock. Any other address is not acknowledged, and the target ignores the bus until the next START.
- R3: In block mode (command bit 7 = 0), the byte after the command is a count x. The next x data bytes are acknowledged and stored in registers n, n+1, and so on. Any data byte beyond x is not acknowledged and is discarded.
- R4: In byte mode (command bit 7 = 1), data bytes follow the command directly. Each one is acknowledged and stored at the next register index, with no count limit.
- R5: A block read is the sequence 0xD2, command, repeated START, 0xD3. The target first sends the value of register 8, then registers n, n+1, and so on. It continues while the host acknowledges. After a host NACK it releases SDA.
- R6: A byte-mode read sends register n as the first byte, with no count byte before it.
- R7: Writes to registers 5 and 7, and to bits 5:0 of register 6, are acknowledged but do not change those bits. Bits 7:6 of register 6 are writable.
- R8: The register index advances by one after each data byte in both directions and wraps from 8 to 0. A command index of 9 or above selects register 0.
- R9: A STOP or START that arrives part-way through a data byte stores nothing from that byte. A START always restarts address reception.
- R10: The target starts pulling SDA low only while SCL is low. It never drives SDA while idle.
- R11: `cfg_regs` bits 8i+7..8i carry register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_regs | output | NREG*8 | Flat register bank contents |

## Verification
The assertions check the following on every cycle:
- SDA is never first pulled low while SCL is high.
- The idle state never drives the line.
- A START or STOP is followed on the next cycle by the ADDR or IDLE state.
- The register vector changes only in the cycle after a write strobe.
- A write strobe appears only while SCL is low.

Some behaviours only the directed scenarios can show, because they depend on byte order and values across a whole transfer:
- the ordering of the count byte ahead of the data;
- the NACK of bytes beyond the written count;
- the masking of fixed fields;
- the index wrap;
- the loss of a half-received byte.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_TX,
        ST_TX_ACK
    } smb_state_e;

    // Power-on value of each register.
    function automatic logic [7:0] reg_default(int idx);
        case (idx)
            0:       return 8'h07;
            1, 2:    return 8'hFF;
            6:       return 8'h45;
            7:       return 8'h11;
            8:       return 8'h05;
            default: return 8'h00;
        endcase
    endfunction

    // Writable bits of each register; cleared bits keep their value.
    function automatic logic [7:0] reg_wmask(int idx);
        case (idx)
            5, 7:    return 8'h00;
            6:       return 8'hC0;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_events.sv
module smb_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_i;
            sda_p <= sda_i;
        end
    end

    assign scl_rise = scl_i & ~scl_p;
    assign scl_fall = ~scl_i & scl_p;
    // SDA edges while SCL is held high are bus conditions.
    assign start_ev = scl_i & scl_p & sda_p & ~sda_i;
    assign stop_ev  = scl_i & scl_p & ~sda_p & sda_i;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_pkg::*;
#(
    parameter int NREG = 9,
    parameter int IDXW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDXW-1:0]   idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NREG*8-1:0] flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] MASK = reg_wmask(g);
        localparam logic [7:0] DEF  = reg_default(g);
        logic [7:0] q;
        if (MASK == 8'h00) begin : g_fixed
            assign q = DEF;
        end else begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= DEF;
                else if (we && idx == IDXW'(g))
                    q <= (wdata & MASK) | (q & ~MASK);
            end
        end
        assign flat[g*8 +: 8] = q;
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (idx == IDXW'(i)) rdata = flat[i*8 +: 8];
    end
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
    import smb_pkg::*;
#(
    parameter int          NREG     = 9,
    parameter int          IDXW     = 4,
    parameter logic [6:0]  DEV_ADDR = 7'h69
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_i,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_ev,
    input  logic            stop_ev,
    input  logic [7:0]      reg_rdata,
    input  logic [7:0]      count_val,
    output logic            reg_we,
    output logic [IDXW-1:0] reg_idx,
    output logic [7:0]      reg_wdata,
    output logic            sda_drive_low,
    output smb_state_e      state_o
);
    smb_state_e      st, nxt;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg, txsh, remain;
    logic [IDXW-1:0] idx;
    logic            rw_q, byte_mode_q, ack_q, host_ack_q;

    wire byte_done = (bitcnt == 4'd8);
    wire addr_hit  = (shreg[7:1] == DEV_ADDR);
    wire wr_ok     = byte_mode_q || (remain != 8'd0);
    wire rx_state  = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_CNT) || (st == ST_WR);
    wire [IDXW-1:0] idx_inc = (idx == IDXW'(NREG - 1)) ? '0 : idx + IDXW'(1);
    wire [IDXW-1:0] cmd_idx = (shreg[6:0] < 7'(NREG)) ? shreg[IDXW-1:0] : '0;

    // Next-state logic
    always_comb begin
        nxt = st;
        if (stop_ev)
            nxt = ST_IDLE;
        else if (start_ev)
            nxt = ST_ADDR;
        else begin
            unique case (st)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_TX : ST_CMD;
                ST_CMD:      if (scl_fall && byte_done) nxt = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) nxt = byte_mode_q ? ST_WR : ST_CNT;
                ST_CNT:      if (scl_fall && byte_done) nxt = ST_CNT_ACK;
                ST_CNT_ACK:  if (scl_fall) nxt = ST_WR;
                ST_WR:       if (scl_fall && byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR;
                ST_TX:       if (scl_fall && bitcnt == 4'd7) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) nxt = host_ack_q ? ST_TX : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            bitcnt      <= 4'd0;
            shreg       <= 8'h00;
            txsh        <= 8'hFF;
            remain      <= 8'h00;
            idx         <= '0;
            rw_q        <= 1'b0;
            byte_mode_q <= 1'b0;
            ack_q       <= 1'b0;
            host_ack_q  <= 1'b0;
        end else begin
            st <= nxt;
            if (start_ev || stop_ev) begin
                bitcnt <= 4'd0;
                ack_q  <= 1'b0;
            end else begin
                if (rx_state && scl_rise && !byte_done) begin
                    shreg  <= {shreg[6:0], sda_i};
                    bitcnt <= bitcnt + 4'd1;
                end
                if (st == ST_TX_ACK && scl_rise)
                    host_ack_q <= ~sda_i;
                if (scl_fall) begin
                    unique case (st)
                        ST_ADDR: if (byte_done) begin
                            rw_q  <= shreg[0];
                            ack_q <= addr_hit;
                        end
                        ST_ADDR_ACK: begin
                            bitcnt <= 4'd0;
                            if (rw_q) begin
                                txsh <= byte_mode_q ? reg_rdata : count_val;
                                if (byte_mode_q) idx <= idx_inc;
                            end
                        end
                        ST_CMD: if (byte_done) begin
                            idx         <= cmd_idx;
                            byte_mode_q <= shreg[7];
                            ack_q       <= 1'b1;
                        end
                        ST_CNT: if (byte_done) begin
                            remain <= shreg;
                            ack_q  <= 1'b1;
                        end
                        ST_WR: if (byte_done) begin
                            ack_q <= wr_ok;
                            if (wr_ok) begin
                                idx <= idx_inc;
                                if (!byte_mode_q) remain <= remain - 8'd1;
                            end
                        end
                        ST_CMD_ACK, ST_CNT_ACK, ST_WR_ACK: bitcnt <= 4'd0;
                        ST_TX: begin
                            bitcnt <= bitcnt + 4'd1;
                            txsh   <= {txsh[6:0], 1'b1};
                        end
                        ST_TX_ACK: if (host_ack_q) begin
                            txsh   <= reg_rdata;
                            idx    <= idx_inc;
                            bitcnt <= 4'd0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Outputs
    always_comb begin
        reg_we    = (st == ST_WR) && scl_fall && byte_done && wr_ok && !start_ev && !stop_ev;
        reg_idx   = idx;
        reg_wdata = shreg;
        state_o   = st;
        unique case (st)
            ST_ADDR_ACK, ST_CMD_ACK, ST_CNT_ACK, ST_WR_ACK: sda_drive_low = ack_q;
            ST_TX:   sda_drive_low = ~txsh[7];
            default: sda_drive_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
    import smb_pkg::*;
#(
    parameter int          NREG      = 9,
    parameter int          COUNT_REG = 8,
    parameter logic [6:0]  DEV_ADDR  = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low,
    output logic [NREG*8-1:0] cfg_regs
);
    localparam int IDXW = $clog2(NREG);

    logic            scl_rise, scl_fall, start_ev, stop_ev;
    logic            reg_we;
    logic [IDXW-1:0] reg_idx;
    logic [7:0]      reg_wdata, reg_rdata;
    smb_state_e      fsm_state;

    smb_line_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_target_fsm #(.NREG(NREG), .IDXW(IDXW), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_i         (sda_i),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_ev      (start_ev),
        .stop_ev       (stop_ev),
        .reg_rdata     (reg_rdata),
        .count_val     (cfg_regs[COUNT_REG*8 +: 8]),
        .reg_we        (reg_we),
        .reg_idx       (reg_idx),
        .reg_wdata     (reg_wdata),
        .sda_drive_low (sda_drive_low),
        .state_o       (fsm_state)
    );

    smb_reg_bank #(.NREG(NREG), .IDXW(IDXW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .flat  (cfg_regs)
    );
endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk
    import smb_pkg::*;
#(
    parameter int NREG = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_drive_low,
    input logic [NREG*8-1:0] cfg_regs,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              reg_we,
    input smb_state_e        fsm_state
);
    // R10: pull-down begins only while SCL is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_i);

    // R10: idle never drives the line
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> !sda_drive_low);

    // R9: STOP returns to idle
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (fsm_state == ST_IDLE));

    // R9: START restarts address reception
    a_r9_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (fsm_state == ST_ADDR));

    // R9: bank changes only after a completed-byte strobe
    a_r9_cfg_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs) |-> $past(reg_we));

    // R3: stores happen in the SCL-low phase
    a_r3_we_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !scl_i);
endmodule

bind smb_cfg_target smb_cfg_target_chk #(.NREG(NREG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .sda_drive_low (sda_drive_low),
    .cfg_regs      (cfg_regs),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .reg_we        (reg_we),
    .fsm_state     (fsm_state)
);

// File: tb/smb_cfg_target_bench.sv
module smb_cfg_target_bench;
    localparam int NREG = 9;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_drive_low;
    logic [NREG*8-1:0] cfg_regs;
    wire  sda_line = sda_h & ~sda_drive_low;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    smb_cfg_target u_smb_cfg_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_h),
        .sda_i         (sda_line),
        .sda_drive_low (sda_drive_low),
        .cfg_regs      (cfg_regs)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] regv(input int i);
        return cfg_regs[i*8 +: 8];
    endfunction

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b;    tick(Q);
        scl_h = 1'b1; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q / 2);
        b = sda_line; tick(Q / 2);
        scl_h = 1'b0; tick(Q);
    endtask

    // Send a byte, then check the target's acknowledge against exp_ack.
    task automatic send_ack(input string tag, input logic [7:0] d, input logic exp_ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        check8(tag, {7'd0, ~b}, {7'd0, exp_ack});
    endtask

    task automatic recv_chk(input string tag, input logic [7:0] exp, input logic give_ack);
        logic [7:0] d;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
        sda_h = 1'b1;
        check8(tag, d, exp);
    endtask

    task automatic t_reset();
        check8("R1 reg0", regv(0), 8'h07);
        check8("R1 reg1", regv(1), 8'hFF);
        check8("R1 reg2", regv(2), 8'hFF);
        check8("R1 reg3", regv(3), 8'h00);
        check8("R1 reg4", regv(4), 8'h00);
        check8("R1 reg5", regv(5), 8'h00);
        check8("R1 reg6", regv(6), 8'h45);
        check8("R1 reg7", regv(7), 8'h11);
        check8("R1 reg8", regv(8), 8'h05);
        check8("R10 idle release", {7'd0, sda_drive_low}, 8'h00);
    endtask

    task automatic t_block_write();
        bus_start();
        send_ack("R2 write addr ack", 8'hD2, 1'b1);
        send_ack("R3 cmd ack", 8'h01, 1'b1);
        send_ack("R3 count ack", 8'h02, 1'b1);
        send_ack("R3 data0 ack", 8'h3C, 1'b1);
        send_ack("R3 data1 ack", 8'hA5, 1'b1);
        bus_stop();
        check8("R3 reg1 stored", regv(1), 8'h3C);
        check8("R11 reg2 slice", regv(2), 8'hA5);
    endtask

    task automatic t_count_limit();
        bus_start();
        send_ack("R2 write addr ack", 8'hD2, 1'b1);
        send_ack("R3 cmd ack", 8'h03, 1'b1);
        send_ack("R3 count ack", 8'h01, 1'b1);
        send_ack("R3 in-count ack", 8'h11, 1'b1);
        send_ack("R3 over-count nack", 8'h22, 1'b0);
        bus_stop();
        check8("R3 reg3 stored", regv(3), 8'h11);
        check8("R3 reg4 untouched", regv(4), 8'h00);
    endtask

    task automatic t_block_read();
        bus_start();
        send_ack("R5 write addr ack", 8'hD2, 1'b1);
        send_ack("R5 cmd ack", 8'h01, 1'b1);
        bus_start();
        send_ack("R2 read addr ack", 8'hD3, 1'b1);
        recv_chk("R5 count byte", 8'h05, 1'b1);
        recv_chk("R5 first data", 8'h3C, 1'b1);
        recv_chk("R5 second data", 8'hA5, 1'b0);
        check8("R5 released after nack", {7'd0, sda_drive_low}, 8'h00);
        bus_stop();
    endtask

    task automatic t_byte_mode();
        bus_start();
        send_ack("R4 addr ack", 8'hD2, 1'b1);
        send_ack("R4 cmd ack", 8'h80, 1'b1);
        send_ack("R4 data ack", 8'h9A, 1'b1);
        bus_stop();
        check8("R4 reg0 stored", regv(0), 8'h9A);
        bus_start();
        send_ack("R6 addr ack", 8'hD2, 1'b1);
        send_ack("R6 cmd ack", 8'h80, 1'b1);
        bus_start();
        send_ack("R6 read addr ack", 8'hD3, 1'b1);
        recv_chk("R6 first byte is data", 8'h9A, 1'b1);
        recv_chk("R6 next byte", 8'h3C, 1'b0);
        bus_stop();
    endtask

    task automatic t_readonly();
        bus_start();
        send_ack("R7 addr ack", 8'hD2, 1'b1);
        send_ack("R7 cmd ack", 8'h85, 1'b1);
        send_ack("R7 reg5 ack", 8'hEE, 1'b1);
        send_ack("R7 reg6 ack", 8'hEE, 1'b1);
        send_ack("R7 reg7 ack", 8'hEE, 1'b1);
        bus_stop();
        check8("R7 reg5 fixed", regv(5), 8'h00);
        check8("R7 reg6 masked", regv(6), 8'hC5);
        check8("R7 reg7 fixed", regv(7), 8'h11);
    endtask

    task automatic t_wrap();
        bus_start();
        send_ack("R8 addr ack", 8'hD2, 1'b1);
        send_ack("R8 cmd ack", 8'h88, 1'b1);
        send_ack("R8 reg8 ack", 8'h03, 1'b1);
        send_ack("R8 wrapped ack", 8'h77, 1'b1);
        bus_stop();
        check8("R8 reg8 stored", regv(8), 8'h03);
        check8("R8 wrapped to reg0", regv(0), 8'h77);
        bus_start();
        send_ack("R8 addr ack", 8'hD2, 1'b1);
        send_ack("R8 cmd ack", 8'h08, 1'b1);
        bus_start();
        send_ack("R8 read addr ack", 8'hD3, 1'b1);
        recv_chk("R5 count follows reg8", 8'h03, 1'b1);
        recv_chk("R8 read reg8", 8'h03, 1'b1);
        recv_chk("R8 read wraps", 8'h77, 1'b0);
        bus_stop();
        bus_start();
        send_ack("R8 addr ack", 8'hD2, 1'b1);
        send_ack("R8 big index ack", 8'h8C, 1'b1);
        send_ack("R8 data ack", 8'h55, 1'b1);
        bus_stop();
        check8("R8 big index hits reg0", regv(0), 8'h55);
    endtask

    task automatic t_wrong_addr();
        bus_start();
        send_ack("R2 foreign addr nack", 8'hA0, 1'b0);
        send_ack("R2 ignored byte nack", 8'h80, 1'b0);
        send_ack("R2 ignored data nack", 8'h00, 1'b0);
        bus_stop();
        check8("R2 bank untouched", regv(0), 8'h55);
    endtask

    task automatic t_abort();
        bus_start();
        send_ack("R9 addr ack", 8'hD2, 1'b1);
        send_ack("R9 cmd ack", 8'h82, 1'b1);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        check8("R9 stop mid-byte", regv(2), 8'hA5);
        bus_start();
        send_ack("R9 addr ack", 8'hD2, 1'b1);
        send_ack("R9 cmd ack", 8'h82, 1'b1);
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        bus_start();
        send_ack("R9 restart addr ack", 8'hD2, 1'b1);
        send_ack("R9 cmd ack", 8'h83, 1'b1);
        send_ack("R9 data ack", 8'h6B, 1'b1);
        bus_stop();
        check8("R9 start mid-byte", regv(2), 8'hA5);
        check8("R9 after restart", regv(3), 8'h6B);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_block_write();
        t_count_limit();
        t_block_read();
        t_byte_mode();
        t_readonly();
        t_wrap();
        t_wrong_addr();
        t_abort();
        tick(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule